// File: doc/BRIEF.md
# Vectorised Compare-to-Predicate Unit

This unit executes a compare-and-branch operation in which each of the two source operands may be marked as scalar or vector. If both operands are scalar, the unit behaves like an ordinary branch comparator: it reports whether the branch should be taken. If at least one operand is a vector, the unit does not branch. It steps an element index from zero up to the vector length minus one. A vector operand reads consecutive registers starting at its base register, while a scalar operand reads its one register for every element. Each element's compare result becomes one bit of a predicate mask, and the finished mask is written once into an integer register. That register is named by the field that would otherwise hold the branch offset.

The unit drives two combinational register-file read addresses and samples the returned data in the same cycle. It handles one element per clock. When it finishes, it pulses `done` together with either a branch decision or a single mask write. Instruction decode, pipelining and hazard handling belong to the surrounding core.

Top module: `vcmp_pred_unit`

## Requirements
- R1: When `start` is accepted with both `vecA` and `vecB` low, `branchValid` and `done` pulse high for one cycle starting after the second rising edge. `branchTaken` carries the compare of register `srcA` against register `srcB`, and `wrEn` stays low.
- R2: For element i, a vector operand reads register (base + i) modulo 32, and a scalar operand reads its base register for every i.
- R3: The scalar-vector, vector-scalar and vector-vector operand combinations all produce a mask write.
- R4: Bit i of the written mask is 1 exactly when the compare for element i is true, for i below the effective length. Every bit at or above the effective length is 0.
- R5: The mask write targets the register number given on `destReg` when `start` was accepted.
- R6: `cmpOp` encodings: 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal. Codes 2 and 3 compare as false.
- R7: A vector operation with effective length L > 0 takes one cycle per element. `done` and `wrEn` pulse together for one cycle starting after the (L+1)-th rising edge from acceptance, and `busy` is high while elements are being processed.
- R8: A vector operation with `vecLen` of 0 writes an all-zero mask, with `done` and `wrEn` pulsing after the acceptance edge itself.
- R9: A `vecLen` above XLEN (32) is treated as XLEN.
- R10: `start` is ignored while `busy` is high: the operation in flight completes with its original operands, length and destination.
- R11: After reset, `done`, `wrEn`, `branchValid`, `branchTaken` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| srcA | input | 5 | Base register of operand A |
| srcB | input | 5 | Base register of operand B |
| vecA | input | 1 | Operand A is a vector |
| vecB | input | 1 | Operand B is a vector |
| vecLen | input | 6 | Vector length (clamped to 32) |
| cmpOp | input | 3 | Compare type |
| destReg | input | 5 | Mask destination register (branch-offset field) |
| rdAddrA | output | 5 | Register-file read address for operand A |
| rdDataA | input | 32 | Register-file read data for operand A |
| rdAddrB | output | 5 | Register-file read address for operand B |
| rdDataB | input | 32 | Register-file read data for operand B |
| branchValid | output | 1 | Scalar branch decision is valid this cycle |
| branchTaken | output | 1 | Scalar branch decision |
| wrEn | output | 1 | Write the mask this cycle |
| wrAddr | output | 5 | Mask write register number |
| wrData | output | 32 | Mask value |
| done | output | 1 | Operation complete |
| busy | output | 1 | Operation in flight |

## Verification
On every cycle, the assertions check the following:
- a scalar decision and a mask write never coincide;
- no written mask has a bit set at or beyond the effective length;
- each `done` carries exactly one result;
- the element index advances by one per cycle;
- the latched length stays in range and is not disturbed by a `start` arriving mid-run.

Some behaviour only the bench scenarios can show, because it needs the compare outcomes and register contents computed in the bench:
- the mask bit values for every compare type and operand combination;
- address wrap-around at the top of the register file;
- exact completion latency for lengths 0, 1, short, full and over-range;
- the destination used for the write.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAL = 2'd1,
    ST_RUN  = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // accept new operation, latch operands
    logic elemEn;      // evaluate one vector element
    logic lastElem;    // current element is the final one
    logic scalarEval;  // evaluate the scalar branch compare
    logic emptyEval;   // zero-length vector: emit empty mask
  } ctrlStrb_t;

  // compare encodings follow the branch function field
  localparam logic [2:0] CMP_EQ  = 3'd0;
  localparam logic [2:0] CMP_NE  = 3'd1;
  localparam logic [2:0] CMP_LT  = 3'd4;
  localparam logic [2:0] CMP_GE  = 3'd5;
  localparam logic [2:0] CMP_LTU = 3'd6;
  localparam logic [2:0] CMP_GEU = 3'd7;

endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VL_W  = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             vecA,
  input  logic             vecB,
  input  logic [VL_W-1:0]  vecLen,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] elemIdx,
  output logic [VL_W-1:0]  vlEff,
  output logic             busy
);

  localparam logic [VL_W-1:0] VL_MAX = VL_W'(XLEN);

  ctrlState_t       state, nextState;
  logic [IDX_W-1:0] idxR;
  logic [VL_W-1:0]  vlR;
  logic [VL_W-1:0]  vlIn;
  logic             bothScalar;

  assign vlIn       = (vecLen > VL_MAX) ? VL_MAX : vecLen;
  assign bothScalar = !vecA && !vecB;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          if (bothScalar)        nextState = ST_SCAL;
          else if (vlIn == '0)   strb.emptyEval = 1'b1;
          else                   nextState = ST_RUN;
        end
      end
      ST_SCAL: begin
        strb.scalarEval = 1'b1;
        nextState       = ST_IDLE;
      end
      ST_RUN: begin
        strb.elemEn   = 1'b1;
        strb.lastElem = (VL_W'(idxR) == vlR - 1'b1);
        if (strb.lastElem) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxR  <= '0;
      vlR   <= '0;
    end else begin
      state <= nextState;
      if (strb.load) begin
        idxR <= '0;
        vlR  <= bothScalar ? '0 : vlIn;
      end else if (strb.elemEn && !strb.lastElem) begin
        idxR <= idxR + 1'b1;
      end
    end
  end

  assign elemIdx = idxR;
  assign vlEff   = vlR;
  assign busy    = (state != ST_IDLE);

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !strb.lastElem) |=> (elemIdx == IDX_W'($past(elemIdx) + 1'b1)));

  // R9
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    vlEff <= VL_MAX);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !strb.lastElem && start) |=> $stable(vlEff));

endmodule

// File: rtl/vcmp_dp.sv
module vcmp_dp
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REG_W = 5,
  parameter int VL_W  = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [IDX_W-1:0] elemIdx,
  input  logic [VL_W-1:0]  vlEff,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic             vecA,
  input  logic             vecB,
  input  logic [2:0]       cmpOp,
  input  logic [REG_W-1:0] destReg,
  output logic [REG_W-1:0] rdAddrA,
  input  logic [XLEN-1:0]  rdDataA,
  output logic [REG_W-1:0] rdAddrB,
  input  logic [XLEN-1:0]  rdDataB,
  output logic             branchValid,
  output logic             branchTaken,
  output logic             wrEn,
  output logic [REG_W-1:0] wrAddr,
  output logic [XLEN-1:0]  wrData,
  output logic             done
);

  localparam int SUM_W = REG_W + IDX_W;

  logic [REG_W-1:0] baseA, baseB, destR;
  logic             vecAR, vecBR;
  logic [2:0]       opR;
  logic [XLEN-1:0]  maskR;
  logic [SUM_W-1:0] sumA, sumB;
  logic             cmpHit;
  logic [XLEN-1:0]  hitBit;

  function automatic logic cmpEval(input logic [2:0] op,
                                   input logic [XLEN-1:0] a,
                                   input logic [XLEN-1:0] b);
    case (op)
      CMP_EQ:  return a == b;
      CMP_NE:  return a != b;
      CMP_LT:  return $signed(a) <  $signed(b);
      CMP_GE:  return $signed(a) >= $signed(b);
      CMP_LTU: return a <  b;
      CMP_GEU: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  // element addressing wraps at the register-file size
  assign sumA    = SUM_W'(baseA) + (vecAR ? SUM_W'(elemIdx) : '0);
  assign sumB    = SUM_W'(baseB) + (vecBR ? SUM_W'(elemIdx) : '0);
  assign rdAddrA = sumA[REG_W-1:0];
  assign rdAddrB = sumB[REG_W-1:0];

  assign cmpHit = cmpEval(opR, rdDataA, rdDataB);
  assign hitBit = cmpHit ? (XLEN'(1) << elemIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseA       <= '0;
      baseB       <= '0;
      destR       <= '0;
      vecAR       <= 1'b0;
      vecBR       <= 1'b0;
      opR         <= '0;
      maskR       <= '0;
      branchValid <= 1'b0;
      branchTaken <= 1'b0;
      wrEn        <= 1'b0;
      wrAddr      <= '0;
      wrData      <= '0;
      done        <= 1'b0;
    end else begin
      branchValid <= 1'b0;
      branchTaken <= 1'b0;
      wrEn        <= 1'b0;
      done        <= 1'b0;
      if (strb.load) begin
        baseA <= srcA;
        baseB <= srcB;
        destR <= destReg;
        vecAR <= vecA;
        vecBR <= vecB;
        opR   <= cmpOp;
        maskR <= '0;
      end
      if (strb.emptyEval) begin
        wrEn   <= 1'b1;
        done   <= 1'b1;
        wrAddr <= destReg;
        wrData <= '0;
      end
      if (strb.elemEn) begin
        maskR <= maskR | hitBit;
        if (strb.lastElem) begin
          wrEn   <= 1'b1;
          done   <= 1'b1;
          wrAddr <= destR;
          wrData <= maskR | hitBit;
        end
      end
      if (strb.scalarEval) begin
        branchValid <= 1'b1;
        branchTaken <= cmpHit;
        done        <= 1'b1;
      end
    end
  end

  // R1
  scalar_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |-> !wrEn);

  // R4
  mask_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((wrData >> vlEff) == '0));

  // R7
  done_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wrEn ^ branchValid));

  // R1
  branch_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.scalarEval |=> (branchValid && done));

endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REG_W = 5,
  parameter int VL_W  = $clog2(XLEN + 1),
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic             vecA,
  input  logic             vecB,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [2:0]       cmpOp,
  input  logic [REG_W-1:0] destReg,
  output logic [REG_W-1:0] rdAddrA,
  input  logic [XLEN-1:0]  rdDataA,
  output logic [REG_W-1:0] rdAddrB,
  input  logic [XLEN-1:0]  rdDataB,
  output logic             branchValid,
  output logic             branchTaken,
  output logic             wrEn,
  output logic [REG_W-1:0] wrAddr,
  output logic [XLEN-1:0]  wrData,
  output logic             done,
  output logic             busy
);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] elemIdx;
  logic [VL_W-1:0]  vlEff;

  vcmp_ctrl #(.XLEN(XLEN), .VL_W(VL_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .vecA(vecA), .vecB(vecB),
    .vecLen(vecLen), .strb(strb), .elemIdx(elemIdx), .vlEff(vlEff), .busy(busy)
  );

  vcmp_dp #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .elemIdx(elemIdx), .vlEff(vlEff),
    .srcA(srcA), .srcB(srcB), .vecA(vecA), .vecB(vecB), .cmpOp(cmpOp),
    .destReg(destReg), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .branchValid(branchValid),
    .branchTaken(branchTaken), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .done(done)
  );

endmodule

// File: tb/vcmp_pred_unit_tb.sv
module vcmp_pred_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  srcA = '0, srcB = '0, destReg = '0;
  logic        vecA = 1'b0, vecB = 1'b0;
  logic [5:0]  vecLen = '0;
  logic [2:0]  cmpOp = '0;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        branchValid, branchTaken, wrEn, done, busy;

  logic [31:0] regs [32];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  vcmp_pred_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .srcA(srcA), .srcB(srcB),
    .vecA(vecA), .vecB(vecB), .vecLen(vecLen), .cmpOp(cmpOp), .destReg(destReg),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .branchValid(branchValid), .branchTaken(branchTaken), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .done(done), .busy(busy)
  );

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cellVal(input int i);
    case (i % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0001;
      6: return 32'h0000_0005;
      default: return 32'hFFFF_FFFB;
    endcase
  endfunction

  // R6 encodings computed in the bench
  function automatic bit refCmp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runOp(input logic [4:0] sA, input logic [4:0] sB, input logic vA, input logic vB,
                       input int vl, input logic [2:0] op, input logic [4:0] dst,
                       input bit poke, input string req);
    int cyc;
    int vlE;
    int expCyc;
    logic [31:0] expMask;
    bit expTaken;
    bit scal;
    scal = !vA && !vB;
    vlE = (vl > 32) ? 32 : vl;
    expMask = '0;
    for (int i = 0; i < vlE; i++) begin
      if (refCmp(op, regs[(sA + (vA ? i : 0)) % 32], regs[(sB + (vB ? i : 0)) % 32]))
        expMask[i] = 1'b1;
    end
    expTaken = refCmp(op, regs[sA], regs[sB]);
    expCyc = scal ? 2 : ((vlE == 0) ? 1 : 1 + vlE);
    @(negedge clk);
    start = 1'b1; srcA = sA; srcB = sB; vecA = vA; vecB = vB;
    vecLen = 6'(vl); cmpOp = op; destReg = dst;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 80) begin
      if (poke && cyc == 2) begin
        // R10: stray start while busy with altered fields
        start = 1'b1; srcA = ~sA; srcB = ~sB; vecLen = 6'd1; destReg = ~dst; cmpOp = 3'd1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == expCyc, {req, " R7 latency"}, 64'(cyc), 64'(expCyc));
    if (scal) begin
      check(branchValid && !wrEn, {req, " R1 branch strobe"}, {62'd0, branchValid, wrEn}, 64'h2);
      check(branchTaken == expTaken, {req, " R1 taken"}, 64'(branchTaken), 64'(expTaken));
    end else begin
      check(wrEn && !branchValid, {req, " R3 write strobe"}, {62'd0, wrEn, branchValid}, 64'h2);
      check(wrData == expMask, {req, " R4 mask"}, 64'(wrData), 64'(expMask));
      check(wrAddr == dst, {req, " R5 dest"}, 64'(wrAddr), 64'(dst));
    end
    @(negedge clk);
    check(!done && !wrEn && !branchValid, {req, " R7 single pulse"}, {61'd0, done, wrEn, branchValid}, 64'h0);
  endtask

  initial begin
    logic [2:0] ops [7];
    int lens [4];
    ops[0] = 3'd0; ops[1] = 3'd1; ops[2] = 3'd4; ops[3] = 3'd5;
    ops[4] = 3'd6; ops[5] = 3'd7; ops[6] = 3'd2;
    lens[0] = 1; lens[1] = 3; lens[2] = 8; lens[3] = 32;
    for (int i = 0; i < 32; i++) regs[i] = cellVal(i * 3 + i / 8);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !wrEn && !branchValid && !branchTaken && !busy, "R11 reset",
          {59'd0, done, wrEn, branchValid, branchTaken, busy}, 64'h0);
    rstN = 1'b1;

    // R1 R6: scalar branch across compare types and register pairs
    for (int o = 0; o < 7; o++)
      for (int p = 0; p < 6; p++)
        runOp(5'(p * 5), 5'(p * 3 + 1), 1'b0, 1'b0, 4, ops[o], 5'd9, 1'b0, "R1 R6 scalar");

    // R2 R3 R4 R6: operand combinations, lengths and compare types
    for (int o = 0; o < 7; o++)
      for (int c = 1; c < 4; c++)
        for (int l = 0; l < 4; l++)
          runOp(5'(o * 7 + l * 11 + 20), 5'(c * 9 + o), c[1], c[0], lens[l], ops[o],
                5'(o + c + l), 1'b0, "R2 R3 R6 vector");

    // R2: wrap past the top register
    runOp(5'd30, 5'd29, 1'b1, 1'b1, 6, 3'd6, 5'd3, 1'b0, "R2 wrap");
    // R8: zero length
    runOp(5'd4, 5'd5, 1'b1, 1'b0, 0, 3'd1, 5'd17, 1'b0, "R8 empty");
    runOp(5'd4, 5'd5, 1'b1, 1'b1, 0, 3'd0, 5'd18, 1'b0, "R8 empty vv");
    // R9: over-range lengths
    runOp(5'd2, 5'd7, 1'b0, 1'b1, 40, 3'd5, 5'd21, 1'b0, "R9 clamp");
    runOp(5'd11, 5'd1, 1'b1, 1'b1, 63, 3'd7, 5'd22, 1'b0, "R9 clamp max");
    // R10: start while busy ignored
    runOp(5'd6, 5'd13, 1'b1, 1'b0, 8, 3'd4, 5'd25, 1'b1, "R10 busy start");
    runOp(5'd1, 5'd2, 1'b1, 1'b1, 32, 3'd0, 5'd26, 1'b1, "R10 busy start full");

    finishRun();
  end

endmodule